// File: doc/BRIEF.md
# Character-Clock Raster Timing Generator

This block produces the raster timing of one display head from values that software loads through a small register write port. A pixel counter splits each character clock into eight pixels. A character counter steps once per character and sets the horizontal timing. A line counter steps once per completed line and sets the vertical timing. Each of the four sync and blank signals is a set/clear flag. The flag is set when its counter reaches a full-width start value. It is cleared when only the low bits of the counter match a short end field, so an end field describes a position modulo a power of two rather than an absolute one.

The totals and display ends are loaded in an offset form. The character total holds the character count minus five, and the line total holds the line count minus two. A display end holds the last visible index, which is the visible count minus one. A control register selects the polarity of each sync output, can silence either sync for power management, and can blank the display enable while the timing keeps running. A retrace flag follows the raw vertical sync interval for software that polls it.

Top module: `crtc_timing_gen`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the following hold. All registers are zero. pix_idx, line_num, hsync, vsync, hblank, vblank and retrace are 0, and disp_en is 1.
- R2: pix_idx counts 0 to 7 and returns to 0. The character counter advances each time pix_idx is 7. The character counter returns to 0 after the character whose index is greater than or equal to the character-total field plus 4, so a line is (field+5) characters long.
- R3: line_num advances on the clock edge that ends the last pixel of a line. It returns to 0 after the line whose index is greater than or equal to the line-total field plus 1, so a frame is (field+2) lines long.
- R4: disp_en is 1 exactly when all three of these hold: the character index is at most the horizontal display-end field, line_num is at most the vertical display-end field, and the screen is not switched off.
- R5: The raw horizontal sync flag sets on the character whose index equals the 9-bit sync-start field. It clears on a later character whose low 5 index bits equal the 5-bit sync-end field. If both match on the same character, setting wins.
- R6: hblank sets on the character whose index equals the blank-start field. It clears on a character whose low 6 index bits equal the 6-bit blank-end field. Setting wins when both match.
- R7: The raw vertical sync flag sets at the start of the line whose number equals the 12-bit sync-start field. It clears on a line whose low 4 bits equal the 4-bit sync-end field. Setting wins when both match.
- R8: vblank sets on the line equal to the blank-start field. It clears on a line whose low 8 bits equal the 8-bit blank-end field. Setting wins when both match.
- R9: Control bit 6 set makes hsync active low, so the output is the inverse of the raw flag. Control bit 7 does the same for vsync.
- R10: Control bit 0 forces hsync to its inactive level, and bit 1 does the same for vsync. The inactive level is the value of the matching polarity bit. Neither bit affects the counters or retrace.
- R11: Control bit 2 forces disp_en low while pix_idx and line_num keep counting.
- R12: retrace equals the raw vertical sync flag, whatever the polarity and disable bits are.
- R13: A write with wr_en high at a clock edge loads wr_data, truncated to the field width, into the register at wr_addr. Counting at that edge still uses the old value. Addresses not listed are ignored. The addresses are:
  - 0: character total (9 bits)
  - 1: horizontal display end (9 bits)
  - 2: horizontal blank start (9 bits)
  - 3: horizontal blank end (6 bits)
  - 4: horizontal sync start (9 bits)
  - 5: horizontal sync end (5 bits)
  - 6: line total (12 bits)
  - 7: vertical display end (12 bits)
  - 8: vertical blank start (12 bits)
  - 9: vertical blank end (8 bits)
  - 10: vertical sync start (12 bits)
  - 11: vertical sync end (4 bits)
  - 12: control, using bits 0, 1, 2, 6 and 7

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 12 | Register write data |
| hsync | output | 1 | Horizontal sync after polarity and disable |
| vsync | output | 1 | Vertical sync after polarity and disable |
| hblank | output | 1 | Horizontal blanking |
| vblank | output | 1 | Vertical blanking |
| disp_en | output | 1 | Display enable |
| pix_idx | output | 3 | Pixel index within the current character |
| line_num | output | 12 | Current scanline number |
| retrace | output | 1 | Raw vertical sync interval flag |

## Verification
The start compare and the truncated end compare of one flag can both match on the same character or line. This happens when the end field equals the low bits of the start value. The bench sets up this case for horizontal sync (start 5, end field 5) and for vertical sync (start 4, end field 4) in a frame long enough for the counters to reach the next low-bit match at character 37 and line 20. It checks on every clock that the flag stays set until that later match. The end of a line and the end of a frame also fall on the same edge as a pixel wrap, and they are judged the same way against a behavioural model.

// File: rtl/crtc_pkg.sv
`timescale 1ns/1ps
// Package crtc_pkg
// Shared register addresses and control-bit positions for the raster
// timing generator. Assumes a 4-bit register address space.
package crtc_pkg;

    typedef enum logic [3:0] {
        REG_H_TOTAL   = 4'd0,
        REG_H_DEND    = 4'd1,
        REG_H_BSTART  = 4'd2,
        REG_H_BEND    = 4'd3,
        REG_H_SSTART  = 4'd4,
        REG_H_SEND    = 4'd5,
        REG_V_TOTAL   = 4'd6,
        REG_V_DEND    = 4'd7,
        REG_V_BSTART  = 4'd8,
        REG_V_BEND    = 4'd9,
        REG_V_SSTART  = 4'd10,
        REG_V_SEND    = 4'd11,
        REG_CONTROL   = 4'd12
    } crtc_reg_e;

    localparam int CTL_HS_OFF  = 0;
    localparam int CTL_VS_OFF  = 1;
    localparam int CTL_SCR_OFF = 2;
    localparam int CTL_HS_LOW  = 6;
    localparam int CTL_VS_LOW  = 7;

endpackage

// File: rtl/crtc_regs.sv
`timescale 1ns/1ps
// Module crtc_regs
// Holds the programmed timing fields and control bits. A write takes
// effect at the clock edge where wr_en is high. Fields are cut to their
// widths. Assumes wr_data is at least as wide as the widest field.
module crtc_regs
    import crtc_pkg::*;
#(
    parameter int H_CW  = 9,
    parameter int V_CW  = 12,
    parameter int HSE_W = 5,
    parameter int HBE_W = 6,
    parameter int VSE_W = 4,
    parameter int VBE_W = 8,
    parameter int AW    = 4,
    parameter int DW    = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    output logic [H_CW-1:0]  h_total,
    output logic [H_CW-1:0]  h_dend,
    output logic [H_CW-1:0]  h_bstart,
    output logic [HBE_W-1:0] h_bend,
    output logic [H_CW-1:0]  h_sstart,
    output logic [HSE_W-1:0] h_send,
    output logic [V_CW-1:0]  v_total,
    output logic [V_CW-1:0]  v_dend,
    output logic [V_CW-1:0]  v_bstart,
    output logic [VBE_W-1:0] v_bend,
    output logic [V_CW-1:0]  v_sstart,
    output logic [VSE_W-1:0] v_send,
    output logic             hs_off,
    output logic             vs_off,
    output logic             scr_off,
    output logic             hs_low,
    output logic             vs_low
);

    // Register file: clear on reset, otherwise load the addressed field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_total  <= '0;
            h_dend   <= '0;
            h_bstart <= '0;
            h_bend   <= '0;
            h_sstart <= '0;
            h_send   <= '0;
            v_total  <= '0;
            v_dend   <= '0;
            v_bstart <= '0;
            v_bend   <= '0;
            v_sstart <= '0;
            v_send   <= '0;
            hs_off   <= 1'b0;
            vs_off   <= 1'b0;
            scr_off  <= 1'b0;
            hs_low   <= 1'b0;
            vs_low   <= 1'b0;
        end else if (wr_en) begin
            case (crtc_reg_e'(wr_addr))
                REG_H_TOTAL:  h_total  <= wr_data[H_CW-1:0];
                REG_H_DEND:   h_dend   <= wr_data[H_CW-1:0];
                REG_H_BSTART: h_bstart <= wr_data[H_CW-1:0];
                REG_H_BEND:   h_bend   <= wr_data[HBE_W-1:0];
                REG_H_SSTART: h_sstart <= wr_data[H_CW-1:0];
                REG_H_SEND:   h_send   <= wr_data[HSE_W-1:0];
                REG_V_TOTAL:  v_total  <= wr_data[V_CW-1:0];
                REG_V_DEND:   v_dend   <= wr_data[V_CW-1:0];
                REG_V_BSTART: v_bstart <= wr_data[V_CW-1:0];
                REG_V_BEND:   v_bend   <= wr_data[VBE_W-1:0];
                REG_V_SSTART: v_sstart <= wr_data[V_CW-1:0];
                REG_V_SEND:   v_send   <= wr_data[VSE_W-1:0];
                REG_CONTROL: begin
                    hs_off  <= wr_data[CTL_HS_OFF];
                    vs_off  <= wr_data[CTL_VS_OFF];
                    scr_off <= wr_data[CTL_SCR_OFF];
                    hs_low  <= wr_data[CTL_HS_LOW];
                    vs_low  <= wr_data[CTL_VS_LOW];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/crtc_axis.sv
`timescale 1ns/1ps
// Module crtc_axis
// One timing axis: a counter that advances on step and wraps once it has
// reached last, plus a sync flag and a blank flag. Each flag sets when the
// next count equals its full-width start. It clears when the low bits of
// the next count equal its short end field. Setting has priority.
// Assumes last is one bit wider than the counter, so that it cannot overflow.
module crtc_axis #(
    parameter int CW   = 9,
    parameter int SE_W = 5,
    parameter int BE_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    input  logic [CW:0]     last,
    input  logic [CW-1:0]   disp_end,
    input  logic [CW-1:0]   sync_start,
    input  logic [SE_W-1:0] sync_end,
    input  logic [CW-1:0]   blank_start,
    input  logic [BE_W-1:0] blank_end,
    output logic [CW-1:0]   count,
    output logic            wrap,
    output logic            sync_act,
    output logic            blank_act,
    output logic            in_disp
);

    logic [CW-1:0] nxt;

    // Wrap detection and the next count value.
    always_comb begin
        wrap = step && ({1'b0, count} >= last);
        nxt  = wrap ? '0 : count + CW'(1);
    end

    // Counter and set/clear flags, all updated on a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count     <= '0;
            sync_act  <= 1'b0;
            blank_act <= 1'b0;
        end else if (step) begin
            count <= nxt;
            if (nxt == sync_start)
                sync_act <= 1'b1;
            else if (nxt[SE_W-1:0] == sync_end)
                sync_act <= 1'b0;
            if (nxt == blank_start)
                blank_act <= 1'b1;
            else if (nxt[BE_W-1:0] == blank_end)
                blank_act <= 1'b0;
        end
    end

    // Visible region of this axis.
    assign in_disp = (count <= disp_end);

    // R2 / R3: the counter only moves on a step.
    assert_hold_R2_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(count));
    // R2 / R3: a wrap returns the counter to zero.
    assert_wrap_R2_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (count == '0));
    // R2 / R3: a step without a wrap adds one.
    assert_incr_R2_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wrap) |=> (count == $past(count) + CW'(1)));
    // R5 / R7: sync rises only on its start position.
    assert_sync_rise_R5_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_act) |-> (count == $past(sync_start)));
    // R5 / R7: sync falls only on a truncated end match, never on its start.
    assert_sync_fall_R5_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_act) |-> ((count[SE_W-1:0] == $past(sync_end)) &&
                             (count != $past(sync_start))));
    // R6 / R8: blank rises only on its start position.
    assert_blank_rise_R6_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blank_act) |-> (count == $past(blank_start)));
    // R6 / R8: blank falls only on a truncated end match.
    assert_blank_fall_R6_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(blank_act) |-> (count[BE_W-1:0] == $past(blank_end)));

endmodule

// File: rtl/crtc_timing_gen.sv
`timescale 1ns/1ps
// Module crtc_timing_gen
// Raster timing generator. It counts pixels in characters, characters in lines and
// lines in frames, and shapes sync, blank, display enable and retrace
// from the programmed fields. Totals are offset-encoded: a line lasts
// (field+5) characters and a frame lasts (field+2) lines.
// Assumes PIX_PER_CHAR is a power of two.
module crtc_timing_gen #(
    parameter int PIX_PER_CHAR = 8,
    parameter int H_CW         = 9,
    parameter int V_CW         = 12,
    parameter int HSE_W        = 5,
    parameter int HBE_W        = 6,
    parameter int VSE_W        = 4,
    parameter int VBE_W        = 8,
    parameter int AW           = 4,
    parameter int H_OFFSET     = 4,
    parameter int V_OFFSET     = 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [AW-1:0]                   wr_addr,
    input  logic [V_CW-1:0]                 wr_data,
    output logic                            hsync,
    output logic                            vsync,
    output logic                            hblank,
    output logic                            vblank,
    output logic                            disp_en,
    output logic [$clog2(PIX_PER_CHAR)-1:0] pix_idx,
    output logic [V_CW-1:0]                 line_num,
    output logic                            retrace
);

    localparam int PIX_W = $clog2(PIX_PER_CHAR);
    localparam logic [PIX_W-1:0] PIX_LAST = PIX_W'(PIX_PER_CHAR - 1);

    logic [H_CW-1:0]  h_total, h_dend, h_bstart, h_sstart;
    logic [HBE_W-1:0] h_bend;
    logic [HSE_W-1:0] h_send;
    logic [V_CW-1:0]  v_total, v_dend, v_bstart, v_sstart;
    logic [VBE_W-1:0] v_bend;
    logic [VSE_W-1:0] v_send;
    logic             hs_off, vs_off, scr_off, hs_low, vs_low;

    logic [PIX_W-1:0] pix_q;
    logic             char_step;
    logic [H_CW:0]    h_last;
    logic [V_CW:0]    v_last;
    logic [H_CW-1:0]  char_cnt;
    logic             h_wrap, v_wrap;
    logic             hs_raw, vs_raw, h_in, v_in;

    crtc_regs #(
        .H_CW(H_CW), .V_CW(V_CW), .HSE_W(HSE_W), .HBE_W(HBE_W),
        .VSE_W(VSE_W), .VBE_W(VBE_W), .AW(AW), .DW(V_CW)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data),
        .h_total(h_total), .h_dend(h_dend), .h_bstart(h_bstart),
        .h_bend(h_bend), .h_sstart(h_sstart), .h_send(h_send),
        .v_total(v_total), .v_dend(v_dend), .v_bstart(v_bstart),
        .v_bend(v_bend), .v_sstart(v_sstart), .v_send(v_send),
        .hs_off(hs_off), .vs_off(vs_off), .scr_off(scr_off),
        .hs_low(hs_low), .vs_low(vs_low)
    );

    // Pixel-within-character counter; the character steps on its last pixel.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pix_q <= '0;
        else
            pix_q <= char_step ? '0 : pix_q + PIX_W'(1);
    end

    // Decode the offset-encoded totals into last indices.
    always_comb begin
        char_step = (pix_q == PIX_LAST);
        h_last    = {1'b0, h_total} + (H_CW+1)'(H_OFFSET);
        v_last    = {1'b0, v_total} + (V_CW+1)'(V_OFFSET);
    end

    crtc_axis #(.CW(H_CW), .SE_W(HSE_W), .BE_W(HBE_W)) u_haxis (
        .clk(clk), .rst_n(rst_n), .step(char_step), .last(h_last),
        .disp_end(h_dend), .sync_start(h_sstart), .sync_end(h_send),
        .blank_start(h_bstart), .blank_end(h_bend),
        .count(char_cnt), .wrap(h_wrap), .sync_act(hs_raw),
        .blank_act(hblank), .in_disp(h_in)
    );

    crtc_axis #(.CW(V_CW), .SE_W(VSE_W), .BE_W(VBE_W)) u_vaxis (
        .clk(clk), .rst_n(rst_n), .step(h_wrap), .last(v_last),
        .disp_end(v_dend), .sync_start(v_sstart), .sync_end(v_send),
        .blank_start(v_bstart), .blank_end(v_bend),
        .count(line_num), .wrap(v_wrap), .sync_act(vs_raw),
        .blank_act(vblank), .in_disp(v_in)
    );

    // Output shaping: polarity, sync disables and screen-off.
    always_comb begin
        hsync   = hs_off ? hs_low : (hs_raw ^ hs_low);
        vsync   = vs_off ? vs_low : (vs_raw ^ vs_low);
        disp_en = h_in && v_in && !scr_off;
        pix_idx = pix_q;
        retrace = vs_raw;
    end

    // R2: the pixel index returns to zero after its last value.
    assert_pix_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_idx == PIX_LAST) |=> (pix_idx == '0));
    // R3: the line number only changes after the last pixel of a character.
    assert_line_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line_num) |-> ($past(pix_idx) == PIX_LAST));
    // R3: a frame wrap lands on line zero.
    assert_frame_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        v_wrap |=> (line_num == '0));
    // R11: while the screen is off, the pixel counter keeps running.
    assert_screen_off_runs_R11: assert property (@(posedge clk) disable iff (!rst_n)
        scr_off |=> (pix_idx != $past(pix_idx)));

endmodule

// File: tb/tb_crtc_timing_gen.sv
`timescale 1ns/1ps
// Bench for crtc_timing_gen: a behavioural model, updated on every rising
// edge, is compared with all outputs on every falling edge.
module tb_crtc_timing_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [11:0] wr_data = '0;
    logic        hsync, vsync, hblank, vblank, disp_en, retrace;
    logic [2:0]  pix_idx;
    logic [11:0] line_num;

    always #5 clk = ~clk;

    crtc_timing_gen dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .hsync(hsync), .vsync(vsync), .hblank(hblank),
        .vblank(vblank), .disp_en(disp_en), .pix_idx(pix_idx),
        .line_num(line_num), .retrace(retrace)
    );

    int  checks = 0;
    int  errors = 0;
    bit  run_cmp = 0;
    bit  done = 0;

    // Model state
    int m_pix = 0, m_ch = 0, m_ln = 0;
    bit m_hs = 0, m_hb = 0, m_vs = 0, m_vb = 0;
    int r [0:12];

    function automatic int field_mask(input int a);
        case (a)
            3:       return 'h3F;
            5:       return 'h1F;
            9:       return 'hFF;
            11:      return 'hF;
            12:      return 'hC7;
            0, 1, 2, 4: return 'h1FF;
            default: return 'hFFF;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model, one step per rising edge (R13: writes land after the step).
    always @(posedge clk) begin : model
        int nc, nl;
        bit hstep, hwrap, vwrap;
        if (!rst_n) begin
            m_pix = 0; m_ch = 0; m_ln = 0;
            m_hs = 0; m_hb = 0; m_vs = 0; m_vb = 0;
            for (int i = 0; i < 13; i++) r[i] = 0;
        end else begin
            nc = m_ch; nl = m_ln;
            hstep = (m_pix == 7);
            hwrap = hstep && (m_ch >= r[0] + 4);
            if (hstep) begin
                nc = hwrap ? 0 : (m_ch + 1) % 512;
                if (nc == r[4]) m_hs = 1; else if ((nc % 32) == r[5]) m_hs = 0;
                if (nc == r[2]) m_hb = 1; else if ((nc % 64) == r[3]) m_hb = 0;
            end
            if (hwrap) begin
                vwrap = (m_ln >= r[6] + 1);
                nl = vwrap ? 0 : (m_ln + 1) % 4096;
                if (nl == r[10]) m_vs = 1; else if ((nl % 16) == r[11]) m_vs = 0;
                if (nl == r[8]) m_vb = 1; else if ((nl % 256) == r[9]) m_vb = 0;
            end
            m_pix = (m_pix + 1) % 8;
            m_ch = nc;
            m_ln = nl;
            if (wr_en && wr_addr <= 12)
                r[wr_addr] = int'(wr_data) & field_mask(int'(wr_addr));
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin : compare
        bit hpol, vpol, e_hs, e_vs, e_de;
        if (run_cmp) begin
            hpol = r[12][6];
            vpol = r[12][7];
            e_hs = r[12][0] ? hpol : (m_hs ^ hpol);
            e_vs = r[12][1] ? vpol : (m_vs ^ vpol);
            e_de = !r[12][2] && (m_ch <= r[1]) && (m_ln <= r[7]);
            chk(pix_idx == m_pix, "R2 pix_idx", pix_idx, m_pix);
            chk(line_num == m_ln, "R3 line_num", line_num, m_ln);
            chk(disp_en == e_de, "R4/R11 disp_en", disp_en, e_de);
            chk(hsync == e_hs, "R5/R9/R10 hsync", hsync, e_hs);
            chk(hblank == m_hb, "R6 hblank", hblank, m_hb);
            chk(vsync == e_vs, "R7/R9/R10 vsync", vsync, e_vs);
            chk(vblank == m_vb, "R8 vblank", vblank, m_vb);
            chk(retrace == m_vs, "R12 retrace", retrace, m_vs);
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 12'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Load all timing fields (R13 address map).
    task automatic program_mode(input int htot, input int hde, input int hbs,
                                input int hbe, input int hss, input int hse,
                                input int vtot, input int vde, input int vbs,
                                input int vbe, input int vss, input int vse);
        wr(0, htot); wr(1, hde); wr(2, hbs); wr(3, hbe); wr(4, hss); wr(5, hse);
        wr(6, vtot); wr(7, vde); wr(8, vbs); wr(9, vbe); wr(10, vss); wr(11, vse);
    endtask

    initial begin : stim
        int ln0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(pix_idx == 0, "R1 pix_idx", pix_idx, 0);
        chk(line_num == 0, "R1 line_num", line_num, 0);
        chk(hsync == 0, "R1 hsync", hsync, 0);
        chk(vsync == 0, "R1 vsync", vsync, 0);
        chk(hblank == 0 && vblank == 0, "R1 blank", {hblank, vblank}, 0);
        chk(retrace == 0, "R1 retrace", retrace, 0);
        chk(disp_en == 1, "R1 disp_en", disp_en, 1);
        rst_n = 1'b1;
        run_cmp = 1;
        run(50);

        // Basic mode: 10 chars per line, 8 lines per frame.
        program_mode(5, 3, 3, 9, 5, 7, 6, 3, 3, 7, 4, 6);
        run(1400);
        // R9: both syncs active low.
        wr(12, 'hC0);
        run(700);
        // R10: both syncs disabled, retrace still follows.
        wr(12, 'hC3);
        run(700);
        wr(12, 'h03);
        run(700);
        // R11: screen off while the counters keep running.
        wr(12, 'h04);
        ln0 = line_num;
        run(100);
        chk(line_num != ln0, "R11 counters run with screen off", line_num, ln0 + 1);
        chk(disp_en == 0, "R11 disp_en forced low", disp_en, 0);
        run(600);
        wr(12, 'h00);
        // R13: an unlisted address changes nothing.
        wr(14, 'hFFF);
        run(700);

        // R5/R7: start and truncated end match on the same position.
        program_mode(40, 30, 31, 42, 5, 5, 25, 15, 16, 26, 4, 4);
        run(20000);
        // R6/R8: wide blank ends and a long total.
        program_mode(100, 79, 80, 40, 85, 30, 40, 29, 30, 42, 33, 5);
        run(40000);

        run_cmp = 0;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #1500000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule